// File: doc/BRIEF.md
# Pulse Interleave Frequency Comparator

This block takes two free-running pulse trains, typically from wheel-speed proximity sensors, and decides which one runs at the higher rate. It does not count pulses over a time window. It watches the order in which rising edges arrive. As long as the inputs alternate edge for edge, neither is ahead and the current verdict stays as it is. When one input produces two rising edges with no edge from the other input between them, that input is declared faster. This takes at most two edges of the faster train.

Both inputs are asynchronous to the system clock. Each passes through a synchronizer and a rising-edge detector. Each input also has its own stall timer, which flags a sensor that has stopped or is stuck at a constant level. When one input stalls, the other input wins. When both stall, the block reports that both inputs are stopped. A pass-through output copies the synchronized level of the winning input, so later logic receives the faster pulse stream. The pulse used to make a switching decision may be cut short, and that is accepted.

All pins are plain levels with no handshake. The pulse inputs may change at any time. The winner code and the pass-through output are registered.

Top module: `pifc_top`

## Requirements
- R1: While reset is asserted and directly after it, `winner` is 0 (undecided) and `pass_out` is 0.
- R2: Two rising edges on `pulse_a` with no rising edge on `pulse_b` between them set `winner` to 1 (A faster). The change happens no later than the third clock edge after the second edge is presented.
- R3: Two rising edges on `pulse_b` with no rising edge on `pulse_a` between them set `winner` to 2 (B faster), with the same latency as R2.
- R4: While the inputs alternate edge for edge, `winner` keeps its current value. This holds for the undecided state as well as for a decided one.
- R5: Rising edges on both inputs captured in the same clock cycle count as one edge on each input. They change neither the winner nor the record of which input produced the last edge.
- R6: Only rising edges count. A falling edge, or a level held high, is not an edge.
- R7: A decided winner has no time limit. It is held for as long as both inputs keep producing edges at intervals shorter than the stall limit, even when the edges alternate.
- R8: If `pulse_b` shows no rising edge for `STALL_CYCLES` clock cycles while `pulse_a` is still active, `winner` becomes 1. The same rule applies with the inputs swapped, giving `winner` 2.
- R9: The rule of R8 also applies when `pulse_b` is stuck high. A constant high level stalls like a constant low level.
- R10: When both inputs are stalled, `winner` is 3 (both stopped) and `pass_out` is 0.
- R11: When `winner` is 1, `pass_out` copies the synchronized level of `pulse_a` one cycle after that level. When `winner` is 2, it copies `pulse_b` in the same way. When `winner` is 0 or 3, `pass_out` is 0. The total delay from an input pin to `pass_out` is three clock edges.
- R12: When a single input resumes after both inputs were stopped, that input becomes the winner within a few cycles of its first rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pulse_a | input | 1 | First sensor pulse train, asynchronous |
| pulse_b | input | 1 | Second sensor pulse train, asynchronous |
| winner | output | 2 | 0 undecided, 1 A faster, 2 B faster, 3 both stopped |
| pass_out | output | 1 | Synchronized level of the winning input, or 0 |

## Verification
The bench drives simultaneous edges after a lone edge on A and then a lone edge on B. A design that treats the simultaneous pair as two ordered edges would wrongly declare B faster. It drives a full pulse on B after a pulse on A. A detector that also counts falling edges would see two B edges in a row and decide B. It drives a long run of alternating edges after A has won. A design that expires a decision after a timeout would drop back to undecided.

It stalls B twice: once held low and once held high, in both cases after the last edge came from B. This way only the stall path, and not the two-edge rule, can hand the win to A. A design whose timer misses a stuck-high input, or whose timer never expires, would then stay undecided. While B is held high and A is low, the bench checks that `pass_out` is 0, which catches a multiplexer that selects the wrong input. It also stops both inputs and then revives one, so that a missing both-stopped state or a lost recovery shows up as the wrong winner code.

// File: rtl/pifc_pkg.sv
package pifc_pkg;
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_A    = 2'd1,
    WIN_B    = 2'd2,
    WIN_IDLE = 2'd3
  } win_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_A    = 2'd1,
    SRC_B    = 2'd2
  } src_e;
endpackage

// File: rtl/pifc_edge_sync.sv
module pifc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], din};
      prev <= sh[STAGES-1];
    end
  end

  assign level = sh[STAGES-1];
  assign rise  = sh[STAGES-1] & ~prev;
endmodule

// File: rtl/pifc_stall_timer.sv
module pifc_stall_timer #(
  parameter int LIMIT = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic stalled
);
  localparam int             W   = $clog2(LIMIT + 1);
  localparam logic [W-1:0]   LIM = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (restart)     cnt <= '0;
    else if (cnt != LIM)  cnt <= cnt + 1'b1;
  end

  assign stalled = (cnt == LIM);
endmodule

// File: rtl/pifc_arbiter.sv
module pifc_arbiter
  import pifc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rise_a,
  input  logic rise_b,
  input  logic stall_a,
  input  logic stall_b,
  output win_e state,
  output src_e last
);
  logic only_a, only_b;
  win_e state_nx;
  src_e last_nx;

  assign only_a = rise_a & ~rise_b;
  assign only_b = rise_b & ~rise_a;

  always_comb begin
    last_nx = last;
    if (only_a)      last_nx = SRC_A;
    else if (only_b) last_nx = SRC_B;

    state_nx = state;
    if (stall_a && stall_b)                state_nx = WIN_IDLE;
    else if (only_a && last == SRC_A)      state_nx = WIN_A;
    else if (only_b && last == SRC_B)      state_nx = WIN_B;
    else if (stall_b)                      state_nx = WIN_A;
    else if (stall_a)                      state_nx = WIN_B;
    else if (state == WIN_IDLE)            state_nx = WIN_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= WIN_NONE;
      last  <= SRC_NONE;
    end else begin
      state <= state_nx;
      last  <= last_nx;
    end
  end
endmodule

// File: rtl/pifc_top.sv
module pifc_top
  import pifc_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int STALL_CYCLES = 1_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pulse_a,
  input  logic       pulse_b,
  output logic [1:0] winner,
  output logic       pass_out
);
  localparam int NCH = 2;

  logic [NCH-1:0] din, lvl, rise, stall;
  win_e           state;
  src_e           last;

  assign din = {pulse_b, pulse_a};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pifc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (din[i]),
      .level (lvl[i]),
      .rise  (rise[i])
    );

    pifc_stall_timer #(.LIMIT(STALL_CYCLES)) u_stall (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (rise[i]),
      .stalled (stall[i])
    );
  end

  pifc_arbiter u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise_a  (rise[0]),
    .rise_b  (rise[1]),
    .stall_a (stall[0]),
    .stall_b (stall[1]),
    .state   (state),
    .last    (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pass_out <= 1'b0;
    else begin
      unique case (state)
        WIN_A:   pass_out <= lvl[0];
        WIN_B:   pass_out <= lvl[1];
        default: pass_out <= 1'b0;
      endcase
    end
  end

  assign winner = state;
endmodule

// File: rtl/pifc_checker.sv
module pifc_checker
  import pifc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] rise,
  input logic [1:0] stall,
  input logic [1:0] lvl,
  input logic [1:0] winner,
  input logic       pass_out
);
  src_e ck_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_last <= SRC_NONE;
    else if (rise[0] && !rise[1]) ck_last <= SRC_A;
    else if (rise[1] && !rise[0]) ck_last <= SRC_B;
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (winner == WIN_NONE && !pass_out));

  a_r2_a_twice: assert property (@(posedge clk) disable iff (!rst_n)
    (rise[0] && !rise[1] && ck_last == SRC_A && !(stall[0] && stall[1]))
    |=> winner == WIN_A);

  a_r3_b_twice: assert property (@(posedge clk) disable iff (!rst_n)
    (rise[1] && !rise[0] && ck_last == SRC_B && !(stall[0] && stall[1]))
    |=> winner == WIN_B);

  a_r4_alternate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rise[0] && !rise[1] && ck_last == SRC_B && stall == 2'b00 && winner != WIN_IDLE)
    |=> winner == $past(winner));

  a_r5_simul_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rise == 2'b11 && stall == 2'b00 && winner != WIN_IDLE)
    |=> winner == $past(winner));

  a_r10_both_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (stall == 2'b11) |=> winner == WIN_IDLE);

  a_r10_pass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (winner == WIN_NONE || winner == WIN_IDLE) |=> !pass_out);

  a_r11_follow_a: assert property (@(posedge clk) disable iff (!rst_n)
    (winner == WIN_A) |=> pass_out == $past(lvl[0]));

  a_r11_follow_b: assert property (@(posedge clk) disable iff (!rst_n)
    (winner == WIN_B) |=> pass_out == $past(lvl[1]));
endmodule

bind pifc_top pifc_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rise     (rise),
  .stall    (stall),
  .lvl      (lvl),
  .winner   (winner),
  .pass_out (pass_out)
);

// File: tb/tb_pifc_top.sv
module tb_pifc_top;
  localparam int STALL = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       a = 1'b0;
  logic       b = 1'b0;
  logic [1:0] winner;
  logic       pass_out;
  int         n_chk = 0;
  int         n_fail = 0;

  always #5 clk = ~clk;

  pifc_top #(.STALL_CYCLES(STALL)) dut (
    .clk(clk), .rst_n(rst_n), .pulse_a(a), .pulse_b(b),
    .winner(winner), .pass_out(pass_out)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    a = 1'b0; b = 1'b0; rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic pulse(logic pa, logic pb);
    if (pa) a = 1'b1;
    if (pb) b = 1'b1;
    idle(4);
    if (pa) a = 1'b0;
    if (pb) b = 1'b0;
    idle(4);
  endtask

  task automatic t_reset();
    a = 1'b0; b = 1'b0; rst_n = 1'b0;
    idle(2);
    chk("R1 winner in reset", winner, 0);
    chk("R1 pass in reset", pass_out, 0);
    rst_n = 1'b1;
    idle(1);
    chk("R1 winner after reset", winner, 0);
  endtask

  task automatic t_a_wins();
    do_reset();
    pulse(1, 0);
    chk("R2 one edge undecided", winner, 0);
    pulse(1, 0);
    chk("R2 A faster", winner, 1);
    a = 1'b1; idle(4);
    chk("R11 pass follows A high", pass_out, 1);
    a = 1'b0; idle(4);
    chk("R11 pass follows A low", pass_out, 0);
    b = 1'b1; idle(4);
    chk("R11 pass ignores B", pass_out, 0);
    b = 1'b0; idle(4);
    chk("R4 single B keeps A", winner, 1);
  endtask

  task automatic t_b_wins();
    do_reset();
    pulse(0, 1);
    pulse(0, 1);
    chk("R3 B faster", winner, 2);
    b = 1'b1; idle(4);
    chk("R11 pass follows B", pass_out, 1);
    b = 1'b0; idle(4);
  endtask

  task automatic t_alternate();
    do_reset();
    pulse(1, 0);
    pulse(0, 1);
    chk("R6 falling edge not counted", winner, 0);
    pulse(1, 0);
    pulse(0, 1);
    chk("R4 alternate undecided", winner, 0);
    do_reset();
    pulse(1, 0);
    pulse(1, 0);
    for (int i = 0; i < 20; i++) begin
      pulse(0, 1);
      idle(8);
      pulse(1, 0);
      idle(8);
      if (i % 5 == 4) chk("R7 decision held without timeout", winner, 1);
    end
  endtask

  task automatic t_simul();
    do_reset();
    pulse(1, 0);
    pulse(1, 1);
    chk("R5 simultaneous no change", winner, 0);
    pulse(0, 1);
    chk("R5 last edge kept as A", winner, 0);
    pulse(1, 0);
    chk("R5 still undecided", winner, 0);
  endtask

  task automatic t_stop_low();
    do_reset();
    pulse(1, 0);
    pulse(0, 1);
    idle(32);
    pulse(1, 0);
    chk("R8 before stall undecided", winner, 0);
    idle(30);
    chk("R8 B stopped gives A", winner, 1);
    a = 1'b1; idle(4);
    chk("R8 pass follows A", pass_out, 1);
    a = 1'b0; idle(4);
  endtask

  task automatic t_stuck_high();
    do_reset();
    pulse(1, 0);
    b = 1'b1;
    idle(8);
    chk("R9 undecided with B high", winner, 0);
    idle(32);
    pulse(1, 0);
    idle(30);
    chk("R9 B stuck high gives A", winner, 1);
    chk("R9 pass low while B high", pass_out, 0);
    a = 1'b1; idle(4);
    chk("R9 pass follows A", pass_out, 1);
    a = 1'b0; idle(4);
    b = 1'b0;
  endtask

  task automatic t_both();
    do_reset();
    idle(STALL + 30);
    chk("R10 both stopped", winner, 3);
    chk("R10 pass low", pass_out, 0);
    a = 1'b1; idle(6);
    chk("R12 A resumes", winner, 1);
    chk("R12 pass follows A", pass_out, 1);
    a = 1'b0;
    idle(STALL + 30);
    chk("R10 both stopped again", winner, 3);
    chk("R10 pass low again", pass_out, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_a_wins();
    t_b_wins();
    t_alternate();
    t_simul();
    t_stop_low();
    t_stuck_high();
    t_both();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule